// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing front end of a 128 KiB byte-addressable serial memory. It watches a two-wire bus (clock line and open-drain data line) with the system clock. Both lines pass through a synchronizer and a glitch filter. The block then finds start and stop conditions and shifts bytes in and out on the bus clock edges.

A transaction begins with an address byte. That byte carries a fixed device code, two strap bits, a memory-half select bit and the read/write flag. A write then takes a high and a low word-address byte, which load a 17-bit pointer, followed by any number of data bytes. Each data byte goes to a page buffer through a single-cycle write strobe. The pointer's low eight bits roll over inside the 256-byte page. A stop that arrives right after a data acknowledge raises a commit pulse, which tells the storage side to start its write cycle. A read streams bytes from the retained pointer. It fetches each byte through a one-cycle read request, and it continues for as long as the master acknowledges.

A busy input from the storage side silences every acknowledge, so the master can poll for the end of a write cycle. A write-protect input refuses data bytes.

Top module: `tws_mem_slave`

## Requirements
- R1: Start (data falling while clock is high) and stop (data rising while clock is high) are recognised on the filtered lines. A pulse on either line that lasts fewer than GLITCH_CYC system clocks has no effect on the transfer in progress.
- R2: The address byte is bits [7:4] device code 4'b1010, [3:2] equal to strap_i (bit 3 compared with strap_i[1]), [1] half select, [0] read when 1. A matching byte is acknowledged (SDA held low in the 9th clock). A non-matching byte is not acknowledged, and the rest of that transaction is ignored until the next start.
- R3: After a write address byte, the high and low word-address bytes are each acknowledged. The pointer then becomes {half select, high byte, low byte}.
- R4: Each acknowledged data byte produces one mem_wr_o pulse, with mem_addr_o equal to the pointer and mem_wdata_o equal to the byte. The pointer's low 8 bits then increment and wrap from FFh to 00h, while bits [16:8] are kept.
- R5: mem_commit_o pulses for one cycle only when a stop is the first bus event after the acknowledge of at least one accepted data byte. A stop inside a byte, a write with no data (dummy write) and a write whose data was refused produce no commit.
- R6: With wp_i high, the address and word-address bytes are still acknowledged. Data bytes are not acknowledged, and no mem_wr_o or mem_commit_o pulse occurs.
- R7: While busy_i is high, no byte is acknowledged, including a matching address byte.
- R8: A read sends bytes MSB first, starting in the clock after the address acknowledge. Each byte is fetched by one mem_rd_o pulse at mem_addr_o. The pointer increments after the 8th bit. A master acknowledge continues with the next byte; a master non-acknowledge ends the read.
- R9: During reads the pointer wraps from 1FFFFh to 00000h.
- R10: The pointer is kept between transactions, so a read with no word address starts from it. A dummy write only loads the pointer.
- R11: A start at any point abandons the current command and waits for a new address byte.
- R12: After reset, and after any stop, SDA is released (sda_oe_o low). sda_oe_o is high only in acknowledge slots and read-data bits, and it changes only while the filtered clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_i | input | 2 | Board strap bits compared with address byte bits [3:2] |
| wp_i | input | 1 | Write protect: refuse data bytes when high |
| busy_i | input | 1 | Storage write cycle in progress: no acknowledges |
| sda_oe_o | output | 1 | Pull the data line low when high |
| mem_addr_o | output | 17 | Address for the current read request or write strobe |
| mem_rd_o | output | 1 | Read request; mem_rdata_i is taken in the same cycle |
| mem_rdata_i | input | 8 | Byte at mem_addr_o, valid while mem_rd_o is high |
| mem_wr_o | output | 1 | Write strobe for one byte into the page buffer |
| mem_wdata_o | output | 8 | Byte written with mem_wr_o |
| mem_commit_o | output | 1 | One-cycle pulse that starts the storage write cycle |

## Verification
The properties assume that the master changes the data line only while the clock line is low, except when it forms a start or stop. They also assume that the two lines never change closer together than the filter length, that no start is attempted while the slave holds the line low, and that wp_i and busy_i move only between transactions. The bench's master keeps every line change a quarter bit period (30 system clocks) away from the next clock edge. It toggles the protect and busy inputs only while the bus is idle. Its only deliberate violations are data-line pulses of 4 clocks, which are shorter than the filter length.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int PTR_W    = 17;
    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = 4;
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam logic [BITCNT_W-1:0] SLOT_ACK  = 4'd8;
    localparam logic [BITCNT_W-1:0] SLOT_DONE = 4'd9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic             rw;
        logic             half;
        logic [BYTE_W-1:0] hi;
    } cmd_t;

    function automatic logic [PTR_W-1:0] page_next(input logic [PTR_W-1:0] a);
        return {a[PTR_W-1:BYTE_W], a[BYTE_W-1:0] + 8'd1};
    endfunction

endpackage

// File: rtl/tws_deglitch.sv
module tws_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       hold_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // A new level is taken only after it has held for GLITCH_CYC clocks.
    always_ff @(posedge clk) begin
        if (rst) begin
            line_o   <= 1'b1;
            hold_cnt <= '0;
        end else if (synced == line_o) begin
            hold_cnt <= '0;
        end else if (hold_cnt == CNT_LAST) begin
            line_o   <= synced;
            hold_cnt <= '0;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events
    import tws_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_q &  sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q &  sda_f;
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
        ev.sda   = sda_f;
    end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        strap_i,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              sda_oe_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_commit_o
);
    phase_t               phase;
    logic [BITCNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0]    sh;
    cmd_t                 cmd;
    logic                 acked;
    logic                 mack;
    logic                 wrote;
    logic [PTR_W-1:0]     ptr;
    logic                 dev_hit;
    logic                 data_ok;

    assign dev_hit = (sh[7:4] == DEV_CODE) && (sh[3:2] == strap_i) && !busy_i;
    assign data_ok = !busy_i && !wp_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            bitcnt       <= '0;
            sh           <= '0;
            cmd          <= '0;
            acked        <= 1'b0;
            mack         <= 1'b0;
            wrote        <= 1'b0;
            ptr          <= '0;
            sda_oe_o     <= 1'b0;
            mem_addr_o   <= '0;
            mem_rd_o     <= 1'b0;
            mem_wr_o     <= 1'b0;
            mem_wdata_o  <= '0;
            mem_commit_o <= 1'b0;
        end else begin
            mem_rd_o     <= 1'b0;
            mem_wr_o     <= 1'b0;
            mem_commit_o <= 1'b0;

            // fetched byte arrives in the cycle after the request
            if (mem_rd_o) begin
                sh       <= mem_rdata_i;
                sda_oe_o <= ~mem_rdata_i[7];
            end

            if (ev.start) begin
                phase    <= PH_DEV;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
                wrote    <= 1'b0;
            end else if (ev.stop) begin
                // the clock rise before a stop counts one bit
                if (phase == PH_WDAT && wrote && bitcnt == 4'd1)
                    mem_commit_o <= 1'b1;
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
                wrote    <= 1'b0;
            end else if (phase != PH_IDLE && ev.rise) begin
                if (bitcnt < SLOT_ACK && phase != PH_RDAT)
                    sh <= {sh[BYTE_W-2:0], ev.sda};
                if (bitcnt == SLOT_ACK && phase == PH_RDAT)
                    mack <= ~ev.sda;
                if (bitcnt != SLOT_DONE)
                    bitcnt <= bitcnt + 1'b1;
            end else if (phase != PH_IDLE && ev.fall) begin
                if (bitcnt == SLOT_ACK) begin
                    unique case (phase)
                        PH_DEV: begin
                            acked    <= dev_hit;
                            sda_oe_o <= dev_hit;
                            cmd.rw   <= sh[0];
                            cmd.half <= sh[1];
                        end
                        PH_AHI: begin
                            acked    <= !busy_i;
                            sda_oe_o <= !busy_i;
                            cmd.hi   <= sh;
                        end
                        PH_ALO: begin
                            acked    <= !busy_i;
                            sda_oe_o <= !busy_i;
                            if (!busy_i) ptr <= {cmd.half, cmd.hi, sh};
                        end
                        PH_WDAT: begin
                            acked    <= data_ok;
                            sda_oe_o <= data_ok;
                            if (data_ok) begin
                                mem_wr_o    <= 1'b1;
                                mem_addr_o  <= ptr;
                                mem_wdata_o <= sh;
                                ptr         <= page_next(ptr);
                                wrote       <= 1'b1;
                            end
                        end
                        PH_RDAT: begin
                            sda_oe_o <= 1'b0;
                            ptr      <= ptr + 1'b1;
                        end
                        default: ;
                    endcase
                end else if (bitcnt == SLOT_DONE) begin
                    sda_oe_o <= 1'b0;
                    bitcnt   <= '0;
                    unique case (phase)
                        PH_DEV: begin
                            if (!acked) begin
                                phase <= PH_IDLE;
                            end else if (cmd.rw) begin
                                phase      <= PH_RDAT;
                                mem_rd_o   <= 1'b1;
                                mem_addr_o <= ptr;
                            end else begin
                                phase <= PH_AHI;
                            end
                        end
                        PH_AHI:  phase <= acked ? PH_ALO  : PH_IDLE;
                        PH_ALO:  phase <= acked ? PH_WDAT : PH_IDLE;
                        PH_WDAT: phase <= PH_WDAT;
                        PH_RDAT: begin
                            if (mack) begin
                                mem_rd_o   <= 1'b1;
                                mem_addr_o <= ptr;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end else if (phase == PH_RDAT && bitcnt != '0) begin
                    sh       <= {sh[BYTE_W-2:0], 1'b0};
                    sda_oe_o <= ~sh[BYTE_W-2];
                end
            end
        end
    end
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              wp_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_commit_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_f;
    logic               scl_f;
    logic               sda_f;
    bus_ev_t            ev;

    assign line_raw = {sda_i, scl_i};
    assign scl_f    = line_f[0];
    assign sda_f    = line_f[1];

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tws_deglitch #(
            .SYNC_STAGES(SYNC_STAGES),
            .GLITCH_CYC (GLITCH_CYC)
        ) u_flt (
            .clk   (clk),
            .rst   (rst),
            .line_i(line_raw[g]),
            .line_o(line_f[g])
        );
    end

    tws_bus_events u_ev (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .ev   (ev)
    );

    tws_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap_i     (strap_i),
        .wp_i        (wp_i),
        .busy_i      (busy_i),
        .mem_rdata_i (mem_rdata_i),
        .sda_oe_o    (sda_oe_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_commit_o(mem_commit_o)
    );
endmodule

// File: rtl/tws_mem_slave_chk.sv
module tws_mem_slave_chk
    import tws_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input bus_ev_t          ev,
    input logic             scl_f,
    input logic             sda_oe,
    input logic             wp,
    input logic             busy,
    input logic [PTR_W-1:0] mem_addr,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             mem_commit
);
    logic             have_prev;
    logic [PTR_W-1:0] prev_a;

    always_ff @(posedge clk) begin
        if (rst || ev.start) begin
            have_prev <= 1'b0;
            prev_a    <= '0;
        end else if (mem_wr) begin
            have_prev <= 1'b1;
            prev_a    <= mem_addr;
        end
    end

    AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f); // R12
    AST_OE_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe); // R12
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && have_prev) |-> (mem_addr[PTR_W-1:8] == prev_a[PTR_W-1:8]
                                   && mem_addr[7:0] == prev_a[7:0] + 8'd1)); // R4
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_commit |=> !mem_commit); // R5
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        mem_commit |-> $past(ev.stop)); // R5
    AST_WR_NOT_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !wp); // R6
    AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !busy); // R7
    AST_RD_WR_APART: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !mem_wr); // R8
endmodule

bind tws_mem_slave tws_mem_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe_o),
    .wp        (wp_i),
    .busy      (busy_i),
    .mem_addr  (mem_addr_o),
    .mem_rd    (mem_rd_o),
    .mem_wr    (mem_wr_o),
    .mem_commit(mem_commit_o)
);

// File: tb/tws_mem_slave_test.sv
`timescale 1ns/1ps
module tws_mem_slave_test;
    localparam int Q = 30;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wp = 1'b0, busy = 1'b0;
    logic sda_oe, mem_rd, mem_wr, mem_commit;
    logic [16:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    wire         sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    tws_mem_slave uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
        .wp_i(wp), .busy_i(busy), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr),
        .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_commit_o(mem_commit)
    );

    // storage model: 4096 bytes indexed by {half, addr[10:0]}
    function automatic int bidx(input logic [16:0] a);
        return int'({a[16], a[10:0]});
    endfunction
    function automatic logic [7:0] ini(input int i);
        return 8'((i * 7) ^ (i >> 4) ^ 8'h3C);
    endfunction
    function automatic logic [7:0] dflt(input logic [16:0] a);
        return ini(bidx(a));
    endfunction

    logic [7:0]  bmem [0:4095];
    logic [16:0] pa [0:511];
    logic [7:0]  pd [0:511];
    int pn = 0, pbase = 0, wr_cnt = 0, cm_cnt = 0;

    assign mem_rdata = bmem[bidx(mem_addr)];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) bmem[i] <= ini(i);
        end else begin
            if (mem_wr) begin
                pa[pn] <= mem_addr; pd[pn] <= mem_wdata;
                pn <= pn + 1; wr_cnt <= wr_cnt + 1;
            end
            if (mem_commit) begin
                for (int k = pbase; k < pn; k++) bmem[bidx(pa[k])] <= pd[k];
                cm_cnt <= cm_cnt + 1;
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] rbuf [0:3];

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
        sda_m = 1'b0; waitc(Q); scl_m = 1'b0; waitc(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(Q);
        sda_m = 1'b1; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitc(Q); scl_m = 1'b1;
            if (glitch && i == 7 && b[i]) begin
                waitc(8); sda_m = 1'b0; waitc(4); sda_m = 1'b1; waitc(2 * Q - 12);
            end else begin
                waitc(2 * Q);
            end
            scl_m = 1'b0; waitc(Q);
        end
        sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
        ack = ~sda_line;
        waitc(Q); scl_m = 1'b0; waitc(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; waitc(Q); scl_m = 1'b1; waitc(2 * Q); scl_m = 1'b0; waitc(Q);
        end
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
            b[i] = sda_line;
            waitc(Q); scl_m = 1'b0; waitc(Q);
        end
        sda_m = ~give_ack; waitc(Q); scl_m = 1'b1; waitc(2 * Q); scl_m = 1'b0; waitc(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dv(input bit half, input bit rd);
        return {4'b1010, STRAP, half, rd};
    endfunction

    // dummy write to a, then read n bytes into rbuf
    task automatic rand_read(input logic [16:0] a, input int n, input string rq);
        bit ak;
        bstart();
        send_byte(dv(a[16], 1'b0), 1'b0, ak); chk(ak, rq, "dummy-write address ack", ak, 1);
        send_byte(a[15:8], 1'b0, ak);         chk(ak, "R3", "high word ack", ak, 1);
        send_byte(a[7:0], 1'b0, ak);          chk(ak, "R3", "low word ack", ak, 1);
        bstart();
        send_byte(dv(1'b0, 1'b1), 1'b0, ak);  chk(ak, "R8", "read address ack", ak, 1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        bstop();
    endtask

    task automatic write_bytes(input logic [16:0] a, input int n, input logic [31:0] d,
                               input bit glitch, input string rq);
        bit ak;
        pbase = pn;
        bstart();
        send_byte(dv(a[16], 1'b0), glitch, ak); chk(ak, rq, "write address ack", ak, 1);
        send_byte(a[15:8], 1'b0, ak);           chk(ak, "R3", "high word ack", ak, 1);
        send_byte(a[7:0], 1'b0, ak);            chk(ak, "R3", "low word ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[31 - 8 * i -: 8], 1'b0, ak); chk(ak, "R4", "data ack", ak, 1);
        end
        bstop();
        waitc(20);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R12", "oe after reset", sda_oe, 0);
        chk(wr_cnt == 0 && cm_cnt == 0, "R5", "no strobes after reset", wr_cnt + cm_cnt, 0);
    endtask

    task automatic t_byte_write();
        int w0 = wr_cnt, c0 = cm_cnt;
        write_bytes(17'h00123, 1, 32'hA5000000, 1'b0, "R2");
        chk(wr_cnt == w0 + 1, "R4", "one write strobe", wr_cnt - w0, 1);
        chk(cm_cnt == c0 + 1, "R5", "commit after stop", cm_cnt - c0, 1);
        c0 = cm_cnt;
        rand_read(17'h00123, 1, "R10");
        chk(rbuf[0] == 8'hA5, "R8", "read back byte write", rbuf[0], 8'hA5);
        chk(cm_cnt == c0, "R5", "dummy write has no commit", cm_cnt - c0, 0);
    endtask

    task automatic t_busy_poll();
        bit ak; logic [7:0] b;
        busy = 1'b1;
        bstart(); send_byte(dv(1'b0, 1'b1), 1'b0, ak); bstop();
        chk(!ak, "R7", "address ack while busy", ak, 0);
        busy = 1'b0;
        bstart(); send_byte(dv(1'b0, 1'b1), 1'b0, ak);
        chk(ak, "R7", "address ack after busy", ak, 1);
        recv_byte(1'b0, b); bstop();
        chk(b == dflt(17'h00124), "R10", "current-address read", b, dflt(17'h00124));
    endtask

    task automatic t_page_write();
        write_bytes(17'h001FE, 4, 32'h11223344, 1'b0, "R2");
        rand_read(17'h001FE, 2, "R3");
        chk(rbuf[0] == 8'h11, "R8", "sequential byte 0", rbuf[0], 8'h11);
        chk(rbuf[1] == 8'h22, "R8", "sequential byte 1", rbuf[1], 8'h22);
        rand_read(17'h00100, 2, "R3");
        chk(rbuf[0] == 8'h33, "R4", "page roll byte 2", rbuf[0], 8'h33);
        chk(rbuf[1] == 8'h44, "R4", "page roll byte 3", rbuf[1], 8'h44);
        rand_read(17'h00200, 1, "R3");
        chk(rbuf[0] == dflt(17'h00200), "R4", "next page untouched", rbuf[0], dflt(17'h00200));
    endtask

    task automatic t_wrap();
        rand_read(17'h1FFFF, 2, "R3");
        chk(rbuf[0] == dflt(17'h1FFFF), "R9", "last address", rbuf[0], dflt(17'h1FFFF));
        chk(rbuf[1] == dflt(17'h00000), "R9", "wrap to zero", rbuf[1], dflt(17'h00000));
    endtask

    task automatic t_protect();
        bit ak; int w0 = wr_cnt, c0 = cm_cnt;
        wp = 1'b1;
        bstart();
        send_byte(dv(1'b0, 1'b0), 1'b0, ak); chk(ak, "R6", "address ack under protect", ak, 1);
        send_byte(8'h01, 1'b0, ak);          chk(ak, "R6", "high word ack under protect", ak, 1);
        send_byte(8'h23, 1'b0, ak);          chk(ak, "R6", "low word ack under protect", ak, 1);
        send_byte(8'h5A, 1'b0, ak);          chk(!ak, "R6", "data refused", ak, 0);
        bstop(); waitc(20);
        wp = 1'b0;
        chk(wr_cnt == w0 && cm_cnt == c0, "R6", "no strobe or commit", wr_cnt - w0 + cm_cnt - c0, 0);
        rand_read(17'h00123, 1, "R2");
        chk(rbuf[0] == 8'hA5, "R6", "protected byte kept", rbuf[0], 8'hA5);
    endtask

    task automatic t_mismatch();
        bit ak;
        bstart(); send_byte({4'b1010, ~STRAP, 2'b01}, 1'b0, ak);
        chk(!ak, "R2", "wrong strap refused", ak, 0);
        send_byte(8'h00, 1'b0, ak);
        chk(!ak, "R2", "rest of transaction ignored", ak, 0);
        bstop();
        bstart(); send_byte({4'b1011, STRAP, 2'b01}, 1'b0, ak); bstop();
        chk(!ak, "R2", "wrong device code refused", ak, 0);
    endtask

    task automatic t_midbyte_stop();
        bit ak; int c0 = cm_cnt;
        pbase = pn;
        bstart();
        send_byte(dv(1'b0, 1'b0), 1'b0, ak);
        send_byte(8'h03, 1'b0, ak);
        send_byte(8'h00, 1'b0, ak);
        send_byte(8'h77, 1'b0, ak); chk(ak, "R4", "data ack before partial byte", ak, 1);
        send_bits(8'hF0, 4);
        bstop(); waitc(20);
        chk(cm_cnt == c0, "R5", "stop inside byte: no commit", cm_cnt - c0, 0);
        rand_read(17'h00300, 1, "R2");
        chk(rbuf[0] == dflt(17'h00300), "R5", "aborted write not stored", rbuf[0], dflt(17'h00300));
    endtask

    task automatic t_abort();
        bit ak; logic [7:0] b;
        bstart();
        send_byte(dv(1'b0, 1'b0), 1'b0, ak);
        send_byte(8'h05, 1'b0, ak);
        bstart();
        send_byte(dv(1'b0, 1'b1), 1'b0, ak);
        chk(ak, "R11", "address after repeated start", ak, 1);
        recv_byte(1'b0, b); bstop();
        chk(b == dflt(17'h00301), "R11", "half-received address discarded", b, dflt(17'h00301));
    endtask

    task automatic t_glitch();
        write_bytes(17'h00410, 1, 32'hC3000000, 1'b1, "R1");
        rand_read(17'h00410, 1, "R1");
        chk(rbuf[0] == 8'hC3, "R1", "short data pulse ignored", rbuf[0], 8'hC3);
    endtask

    initial begin
        waitc(10); rst = 1'b0; waitc(20);
        t_reset();
        t_byte_write();
        t_busy_poll();
        t_page_write();
        t_wrap();
        t_protect();
        t_mismatch();
        t_midbyte_stop();
        t_abort();
        t_glitch();
        chk(sda_oe == 1'b0, "R12", "line released at end", sda_oe, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule